// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small bank of ownership latches that two independent ports share in order to pass tokens for shared resources. Each port selects the bank with its own semaphore select, picks a latch with an index, and either writes or reads one latch per cycle. Writing a request claims a latch. Reading the latch back tells the port whether it now holds it. Writing a release gives it up. At no time can both ports own the same latch.

A request made while the other port holds the latch is not lost. It stays pending inside the latch and turns into ownership in the cycle after the owner releases. This lets a port post its claim once and then poll. Both ports run on one clock. Writes change the latch state at the next rising edge. Reads are combinational on the current state.

Top module: `dualPortSemaphore`

## Requirements
- R1: After reset every latch is free, and a read from either port at any index returns all ones.
- R2: A write whose data bit 0 is 0 is a request. A request to a free latch makes the requesting port its owner from the next cycle. A read then returns all zeros to the owner and all ones to the other port.
- R3: No latch is ever owned by both ports. Two reads of the same index in the same cycle never both return all zeros.
- R4: A request made while the other port owns the latch leaves the owner unchanged and records a pending claim for the requester.
- R5: A write whose data bit 0 is 1 is a release. A release by the owner hands the latch to the other port from the next cycle if that port has a pending claim, and frees it otherwise.
- R6: If both ports request the same free latch in the same cycle, the left port becomes owner and the right port's claim is held pending.
- R7: Only bit 0 of the write data is decoded; the other bits have no effect. Read data is always either all zeros or all ones.
- R8: A release from a port with a pending claim withdraws that claim. A release from a port that neither owns nor waits on the latch has no effect.
- R9: A cycle with the port's semaphore select low changes no latch, even with the write strobe high. Read data is zero whenever the port is not performing a read.
- R10: An access to one index never changes the state of any other latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lSemEn | input | 1 | Left port semaphore select |
| lWrEn | input | 1 | Left port write strobe (0 = read) |
| lIdx | input | IDX_W (3) | Left port latch index |
| lWrData | input | DATA_W (16) | Left port write data; bit 0 decoded |
| lRdData | output | DATA_W (16) | Left port read status |
| rSemEn | input | 1 | Right port semaphore select |
| rWrEn | input | 1 | Right port write strobe (0 = read) |
| rIdx | input | IDX_W (3) | Right port latch index |
| rWrData | input | DATA_W (16) | Right port write data; bit 0 decoded |
| rRdData | output | DATA_W (16) | Right port read status |

## Verification
Every latch is driven into each of five starting states: free, left-owned, right-owned, left-owned with right waiting, and right-owned with left waiting. From each state all nine pairs of left and right actions (idle, request, release) are applied. Reads from both ports right after the pair separate ownership from pending claims. Two further releases, one from each port in turn, expose any pending claim the first read could not show, so hand-off, withdrawal and left priority can each be told apart. Random upper data bits on every write, writes with the select low, and a read of the neighbouring index confirm that nothing outside bit 0 of a selected write moves a latch.

// File: rtl/semPkg.sv
package semPkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } ownerE;

  typedef struct packed {
    logic reqL;
    logic relL;
    logic reqR;
    logic relR;
  } semStrobeT;
endpackage

// File: rtl/semCtrl.sv
module semCtrl
  import semPkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              lSemEn,
  input  logic              lWrEn,
  input  logic [IDX_W-1:0]  lIdx,
  input  logic [DATA_W-1:0] lWrData,
  input  logic              rSemEn,
  input  logic              rWrEn,
  input  logic [IDX_W-1:0]  rIdx,
  input  logic [DATA_W-1:0] rWrData,
  output semStrobeT         strobes [NUM_SEM],
  output logic              lRdEn,
  output logic              rRdEn
);
  logic lWrite, rWrite;

  assign lWrite = lSemEn & lWrEn;
  assign rWrite = rSemEn & rWrEn;
  assign lRdEn  = lSemEn & ~lWrEn;
  assign rRdEn  = rSemEn & ~rWrEn;

  for (genvar k = 0; k < NUM_SEM; k++) begin : gDec
    logic lHit, rHit;
    assign lHit = lWrite & (lIdx == IDX_W'(k));
    assign rHit = rWrite & (rIdx == IDX_W'(k));
    always_comb begin
      strobes[k].reqL = lHit & ~lWrData[0];
      strobes[k].relL = lHit &  lWrData[0];
      strobes[k].reqR = rHit & ~rWrData[0];
      strobes[k].relR = rHit &  rWrData[0];
    end
  end
endmodule

// File: rtl/semCell.sv
module semCell
  import semPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  semStrobeT strobe,
  output logic      ownL,
  output logic      ownR,
  output logic      pendL,
  output logic      pendR
);
  ownerE owner, ownerNxt;
  logic  pendLQ, pendRQ;
  logic  wantL, wantR;
  logic  pendLNxt, pendRNxt;

  always_comb begin
    wantL = (owner == OWN_LEFT) | pendLQ;
    wantR = (owner == OWN_RIGHT) | pendRQ;
    if (strobe.relL) wantL = 1'b0;
    if (strobe.reqL) wantL = 1'b1;
    if (strobe.relR) wantR = 1'b0;
    if (strobe.reqR) wantR = 1'b1;

    if (owner == OWN_LEFT && wantL)       ownerNxt = OWN_LEFT;
    else if (owner == OWN_RIGHT && wantR) ownerNxt = OWN_RIGHT;
    else if (wantL)                       ownerNxt = OWN_LEFT;
    else if (wantR)                       ownerNxt = OWN_RIGHT;
    else                                  ownerNxt = OWN_NONE;

    pendLNxt = wantL & (ownerNxt != OWN_LEFT);
    pendRNxt = wantR & (ownerNxt != OWN_RIGHT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner  <= OWN_NONE;
      pendLQ <= 1'b0;
      pendRQ <= 1'b0;
    end else begin
      owner  <= ownerNxt;
      pendLQ <= pendLNxt;
      pendRQ <= pendRNxt;
    end
  end

  assign ownL  = (owner == OWN_LEFT);
  assign ownR  = (owner == OWN_RIGHT);
  assign pendL = pendLQ;
  assign pendR = pendRQ;
endmodule

// File: rtl/semBank.sv
module semBank
  import semPkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  semStrobeT         strobes [NUM_SEM],
  input  logic              lRdEn,
  input  logic [IDX_W-1:0]  lIdx,
  input  logic              rRdEn,
  input  logic [IDX_W-1:0]  rIdx,
  output logic [DATA_W-1:0] lRdData,
  output logic [DATA_W-1:0] rRdData,
  output logic [NUM_SEM-1:0] ownLVec,
  output logic [NUM_SEM-1:0] ownRVec,
  output logic [NUM_SEM-1:0] pendLVec,
  output logic [NUM_SEM-1:0] pendRVec
);
  for (genvar k = 0; k < NUM_SEM; k++) begin : gCell
    semCell uCell (
      .clk   (clk),
      .rstN  (rstN),
      .strobe(strobes[k]),
      .ownL  (ownLVec[k]),
      .ownR  (ownRVec[k]),
      .pendL (pendLVec[k]),
      .pendR (pendRVec[k])
    );
  end

  assign lRdData = lRdEn ? {DATA_W{~ownLVec[lIdx]}} : '0;
  assign rRdData = rRdEn ? {DATA_W{~ownRVec[rIdx]}} : '0;
endmodule

// File: rtl/dualPortSemaphore.sv
module dualPortSemaphore
  import semPkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lSemEn,
  input  logic              lWrEn,
  input  logic [IDX_W-1:0]  lIdx,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  input  logic              rSemEn,
  input  logic              rWrEn,
  input  logic [IDX_W-1:0]  rIdx,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData
);
  semStrobeT          strobes [NUM_SEM];
  logic               lRdEn, rRdEn;
  logic [NUM_SEM-1:0] ownLVec, ownRVec, pendLVec, pendRVec;

  semCtrl #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) uCtrl (
    .lSemEn (lSemEn),
    .lWrEn  (lWrEn),
    .lIdx   (lIdx),
    .lWrData(lWrData),
    .rSemEn (rSemEn),
    .rWrEn  (rWrEn),
    .rIdx   (rIdx),
    .rWrData(rWrData),
    .strobes(strobes),
    .lRdEn  (lRdEn),
    .rRdEn  (rRdEn)
  );

  semBank #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) uBank (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .lRdEn   (lRdEn),
    .lIdx    (lIdx),
    .rRdEn   (rRdEn),
    .rIdx    (rIdx),
    .lRdData (lRdData),
    .rRdData (rRdData),
    .ownLVec (ownLVec),
    .ownRVec (ownRVec),
    .pendLVec(pendLVec),
    .pendRVec(pendRVec)
  );
endmodule

// File: rtl/semChk.sv
module semChk #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input logic               clk,
  input logic               rstN,
  input logic               lSemEn,
  input logic               lWrEn,
  input logic [IDX_W-1:0]   lIdx,
  input logic [DATA_W-1:0]  lWrData,
  input logic [DATA_W-1:0]  lRdData,
  input logic               rSemEn,
  input logic               rWrEn,
  input logic [IDX_W-1:0]   rIdx,
  input logic [DATA_W-1:0]  rWrData,
  input logic [DATA_W-1:0]  rRdData,
  input logic [NUM_SEM-1:0] ownLVec,
  input logic [NUM_SEM-1:0] ownRVec,
  input logic [NUM_SEM-1:0] pendLVec,
  input logic [NUM_SEM-1:0] pendRVec
);
  // R3
  no_double_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lSemEn && !lWrEn && rSemEn && !rWrEn && lIdx == rIdx) |->
      !(lRdData == '0 && rRdData == '0));

  // R7
  left_read_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lRdData == '0) || (lRdData == '1));

  // R7
  right_read_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rRdData == '0) || (rRdData == '1));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(lSemEn && lWrEn) && !(rSemEn && rWrEn)) |=>
      ($stable(ownLVec) && $stable(ownRVec) && $stable(pendLVec) && $stable(pendRVec)));

  for (genvar k = 0; k < NUM_SEM; k++) begin : gLatch
    logic lReq, lRel, rReq, rRel;
    assign lReq = lSemEn && lWrEn && lIdx == IDX_W'(k) && !lWrData[0];
    assign lRel = lSemEn && lWrEn && lIdx == IDX_W'(k) &&  lWrData[0];
    assign rReq = rSemEn && rWrEn && rIdx == IDX_W'(k) && !rWrData[0];
    assign rRel = rSemEn && rWrEn && rIdx == IDX_W'(k) &&  rWrData[0];

    // R6
    left_wins_tie_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ownLVec[k] && !ownRVec[k] && !pendLVec[k] && !pendRVec[k] && lReq && rReq) |=>
        (ownLVec[k] && pendRVec[k]));

    // R4
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ownRVec[k] && lReq && !rRel) |=> (ownRVec[k] && pendLVec[k]));

    // R5
    handoff_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ownLVec[k] && lRel && pendRVec[k] && !rRel) |=> (ownRVec[k] && !pendRVec[k]));

    // R2
    free_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ownLVec[k] && !ownRVec[k] && rReq && !lReq) |=> ownRVec[k]);
  end
endmodule

bind dualPortSemaphore semChk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .lSemEn  (lSemEn),
  .lWrEn   (lWrEn),
  .lIdx    (lIdx),
  .lWrData (lWrData),
  .lRdData (lRdData),
  .rSemEn  (rSemEn),
  .rWrEn   (rWrEn),
  .rIdx    (rIdx),
  .rWrData (rWrData),
  .rRdData (rRdData),
  .ownLVec (ownLVec),
  .ownRVec (ownRVec),
  .pendLVec(pendLVec),
  .pendRVec(pendRVec)
);

// File: tb/tb_dualPortSemaphore.sv
module tb_dualPortSemaphore;
  localparam int NUM_SEM = 8;
  localparam int DATA_W  = 16;
  localparam int IDX_W   = $clog2(NUM_SEM);

  logic              clk = 1'b0;
  logic              rstN;
  logic              lSemEn, lWrEn, rSemEn, rWrEn;
  logic [IDX_W-1:0]  lIdx, rIdx;
  logic [DATA_W-1:0] lWrData, rWrData, lRdData, rRdData;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  // reference model: owner 0 free, 1 left, 2 right
  int mOwn [NUM_SEM];
  bit mPL  [NUM_SEM];
  bit mPR  [NUM_SEM];

  always #2.5 clk = ~clk;

  dualPortSemaphore #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN),
    .lSemEn(lSemEn), .lWrEn(lWrEn), .lIdx(lIdx), .lWrData(lWrData), .lRdData(lRdData),
    .rSemEn(rSemEn), .rWrEn(rWrEn), .rIdx(rIdx), .rWrData(rWrData), .rRdData(rRdData)
  );

  task automatic cmp(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // ops: 0 idle, 1 request, 2 release
  task automatic modelStep(int lop, int rop, int idx);
    if (lop == 2) begin
      if (mOwn[idx] == 1) mOwn[idx] = 0;
      mPL[idx] = 0;
    end
    if (rop == 2) begin
      if (mOwn[idx] == 2) mOwn[idx] = 0;
      mPR[idx] = 0;
    end
    if (lop == 1 && mOwn[idx] != 1) mPL[idx] = 1;
    if (rop == 1 && mOwn[idx] != 2) mPR[idx] = 1;
    if (mOwn[idx] == 0) begin
      if (mPL[idx]) begin mOwn[idx] = 1; mPL[idx] = 0; end
      else if (mPR[idx]) begin mOwn[idx] = 2; mPR[idx] = 0; end
    end
  endtask

  task automatic idlePorts();
    lSemEn = 0; lWrEn = 0; rSemEn = 0; rWrEn = 0;
    lWrData = '0; rWrData = '0;
  endtask

  // R7: upper data bits random on every write
  task automatic applyOps(int lop, int rop, int idx);
    @(negedge clk);
    lSemEn = (lop != 0); lWrEn = (lop != 0); lIdx = IDX_W'(idx);
    rSemEn = (rop != 0); rWrEn = (rop != 0); rIdx = IDX_W'(idx);
    lWrData = DATA_W'($urandom); lWrData[0] = (lop == 2);
    rWrData = DATA_W'($urandom); rWrData[0] = (rop == 2);
    @(posedge clk);
    #1 idlePorts();
    modelStep(lop, rop, idx);
  endtask

  // R9: strobe and data driven with select low
  task automatic ghostWrite(int idx, bit bit0);
    @(negedge clk);
    lSemEn = 0; lWrEn = 1; lIdx = IDX_W'(idx); lWrData = DATA_W'($urandom); lWrData[0] = bit0;
    rSemEn = 0; rWrEn = 1; rIdx = IDX_W'(idx); rWrData = DATA_W'($urandom); rWrData[0] = bit0;
    @(posedge clk);
    #1 idlePorts();
  endtask

  task automatic readBoth(int idx, string req);
    @(negedge clk);
    lSemEn = 1; lWrEn = 0; lIdx = IDX_W'(idx);
    rSemEn = 1; rWrEn = 0; rIdx = IDX_W'(idx);
    #1;
    cmp(req, lRdData, (mOwn[idx] == 1) ? '0 : '1);
    cmp(req, rRdData, (mOwn[idx] == 2) ? '0 : '1);
    idlePorts();
    #1;
    cmp("R9 idle read data", lRdData, '0);
    cmp("R9 idle read data", rRdData, '0);
  endtask

  initial begin
    for (int i = 0; i < NUM_SEM; i++) begin mOwn[i] = 0; mPL[i] = 0; mPR[i] = 0; end
    idlePorts(); lIdx = '0; rIdx = '0;
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    for (int i = 0; i < NUM_SEM; i++) readBoth(i, "R1 reset state");

    for (int idx = 0; idx < NUM_SEM; idx++) begin
      for (int st = 0; st < 5; st++) begin
        for (int lop = 0; lop < 3; lop++) begin
          for (int rop = 0; rop < 3; rop++) begin
            applyOps(2, 2, idx);
            case (st)
              1: applyOps(1, 0, idx);
              2: applyOps(0, 1, idx);
              3: applyOps(1, 1, idx);              // R6 tie
              4: begin applyOps(0, 1, idx); applyOps(1, 0, idx); end  // R4
              default: ;
            endcase
            ghostWrite(idx, 1'b1);
            ghostWrite(idx, 1'b0);
            readBoth(idx, "R9 select-low write");
            applyOps(lop, rop, idx);
            readBoth(idx, "R2 R4 R6 R8 after op pair");
            applyOps(2, 0, idx);
            readBoth(idx, "R5 R8 after left release");
            applyOps(0, 2, idx);
            readBoth(idx, "R5 R8 after right release");
            readBoth((idx + 1) % NUM_SEM, "R10 neighbour untouched");
          end
        end
      end
    end

    // R3: contested latch, both see status in same cycle
    applyOps(0, 1, 3);
    applyOps(1, 0, 3);
    readBoth(3, "R3 exclusive owner");
    applyOps(0, 2, 3);
    readBoth(3, "R3 R5 handoff to left");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule